// File: doc/BRIEF.md
# Sector Protection and Lock Controller

This block keeps one protection flag for each uniform sector of a serial flash device, together with a lock flag that freezes those flags. The command front-end decodes protect-sector, unprotect-sector and status-register writes and hands them to the block as single-cycle request pulses. The front-end passes the sector field of the address, bits A21..A16 when the defaults are used, rather than the full byte address.

The block answers two questions. The first is whether a program or erase at a queried sector is allowed. The second is whether a full-chip erase is allowed. It also returns the protection flag of the queried sector for readback, and a two-bit summary code for the status register.

The lock flag takes its new value from status bit 7. A hardware write-protect input, active low, decides whether a set lock may be cleared. A status write also performs a global protect or a global unprotect. Status bits 5..2 select which one, and the lock value held before that write decides whether it happens at all.

Top module: `sector_guard`

## Requirements
- R1: After reset, every sector flag reads 1 (protected), `locked` reads 0 and `summary` reads 2'b11.
- R2: A `cmd_prot` pulse with `wel` high and the lock clear sets the flag of sector `cmd_sec`. The change is visible on `q_prot` after the next rising edge.
- R3: A `cmd_unprot` pulse with `wel` high and the lock clear clears the flag of sector `cmd_sec`.
- R4: A request made while `wel` is low changes no sector flag and does not change the lock.
- R5: While `locked` is 1, protect, unprotect and global requests leave every sector flag unchanged.
- R6: A status write with `wel` high performs a global action, but only if the lock was 0 before the write. With `sr_gbits` = 4'b1111 (status bits 5..2) it sets every flag. With 4'b0000 it clears every flag. Any other value leaves the flags unchanged. The lock value written in the same request has no bearing on this.
- R7: A status write with `wel` high loads `sr_lock` (status bit 7) into the lock. If the lock is 1 and `wp_n` is 0, the lock stays 1. A 0-to-1 change is allowed whatever the level of `wp_n`.
- R8: `summary` reads 2'b00 when no flag is set, 2'b11 when all flags are set, and 2'b01 otherwise. It never reads 2'b10.
- R9: With `q_chip` low, `q_allow` is 1 exactly when the flag of `q_sec` is 0. With `q_chip` high, `q_allow` is 1 exactly when no flag is set.
- R10: `wel_clr` is high for one cycle, after the edge that takes any protect, unprotect or status-write request made with `wel` high. It is low at all other times.
- R11: When requests collide in one cycle, a status write takes precedence over protect, and protect takes precedence over unprotect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wp_n | input | 1 | Hardware write-protect, active low |
| wel | input | 1 | Write-enable latch state from the front-end |
| cmd_prot | input | 1 | Protect-sector request pulse |
| cmd_unprot | input | 1 | Unprotect-sector request pulse |
| cmd_sec | input | SW | Sector index for protect and unprotect |
| sr_wr | input | 1 | Status-register write request pulse |
| sr_lock | input | 1 | Written status bit 7 (lock) |
| sr_gbits | input | 4 | Written status bits 5..2 |
| q_sec | input | SW | Sector index for the permission query and readback |
| q_chip | input | 1 | Query a full-chip erase instead of a single sector |
| q_prot | output | 1 | Protection flag of sector `q_sec` |
| q_allow | output | 1 | Program or erase permitted |
| summary | output | 2 | Protection summary code |
| locked | output | 1 | Current lock value |
| wel_clr | output | 1 | One-cycle request to clear the write-enable latch |

## Verification
The bench builds the block with its default of 64 sectors. At that size the all-protected and none-protected summary codes are reached only through global writes. Random per-sector traffic spreads over a register wide enough that the mixed code dominates. A reduced build of 4 sectors is the one that lets single-sector commands alone walk the summary through all three legal codes. For that reason the directed cases drive those transitions explicitly, and they also pin the timing of the lock flag against each global request.

// File: rtl/sector_guard.sv
module sector_guard #(
  parameter int SECTORS = 64,
  parameter int SW      = $clog2(SECTORS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wp_n,
  input  logic          wel,
  input  logic          cmd_prot,
  input  logic          cmd_unprot,
  input  logic [SW-1:0] cmd_sec,
  input  logic          sr_wr,
  input  logic          sr_lock,
  input  logic [3:0]    sr_gbits,
  input  logic [SW-1:0] q_sec,
  input  logic          q_chip,
  output logic          q_prot,
  output logic          q_allow,
  output logic [1:0]    summary,
  output logic          locked,
  output logic          wel_clr
);
  logic [SECTORS-1:0] prot;

  wire g_all  = &sr_gbits;
  wire g_none = ~|sr_gbits;
  wire any_req = sr_wr | cmd_prot | cmd_unprot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prot    <= '1;
      locked  <= 1'b0;
      wel_clr <= 1'b0;
    end else begin
      wel_clr <= wel & any_req;
      if (wel && sr_wr) begin
        locked <= (locked & ~wp_n) | sr_lock;
        if (!locked) begin
          if (g_all)       prot <= '1;
          else if (g_none) prot <= '0;
        end
      end else if (wel && !locked && cmd_prot) begin
        prot[cmd_sec] <= 1'b1;
      end else if (wel && !locked && cmd_unprot) begin
        prot[cmd_sec] <= 1'b0;
      end
    end
  end

  assign q_prot  = prot[q_sec];
  assign q_allow = q_chip ? ~|prot : ~prot[q_sec];
  assign summary = (&prot) ? 2'b11 : (|prot) ? 2'b01 : 2'b00;
endmodule

module sector_guard_chk #(
  parameter int SECTORS = 64
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wp_n,
  input logic               wel,
  input logic               cmd_prot,
  input logic               cmd_unprot,
  input logic               sr_wr,
  input logic               q_chip,
  input logic               q_allow,
  input logic [1:0]         summary,
  input logic               locked,
  input logic               wel_clr,
  input logic [SECTORS-1:0] prot
);
  p_nowel_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wel) |-> (prot == $past(prot)) && (locked == $past(locked)));

  p_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(locked) |-> prot == $past(prot));

  p_lock_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(locked && !wp_n) |-> locked);

  p_no_reserved_r8: assert property (@(posedge clk) disable iff (!rst_n)
    summary != 2'b10);

  p_full_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (summary == 2'b11) |-> (&prot));

  p_chip_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (q_chip && q_allow) |-> (prot == '0));

  p_welclr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wel_clr |-> $past(wel && (sr_wr || cmd_prot || cmd_unprot)));
endmodule

bind sector_guard sector_guard_chk #(.SECTORS(SECTORS)) u_chk (
  .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .wel(wel), .cmd_prot(cmd_prot),
  .cmd_unprot(cmd_unprot), .sr_wr(sr_wr), .q_chip(q_chip), .q_allow(q_allow),
  .summary(summary), .locked(locked), .wel_clr(wel_clr), .prot(prot)
);

// File: tb/sector_guard_tb.sv
module sector_guard_tb;
  localparam int N  = 64;
  localparam int SW = 6;

  logic clk = 0, rst_n = 0;
  logic wp_n = 1, wel = 0, cmd_prot = 0, cmd_unprot = 0, sr_wr = 0, sr_lock = 0, q_chip = 0;
  logic [SW-1:0] cmd_sec = 0, q_sec = 0;
  logic [3:0] sr_gbits = 0;
  logic q_prot, q_allow, locked, wel_clr;
  logic [1:0] summary;

  logic [N-1:0] m_prot;
  logic m_lock;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  sector_guard #(.SECTORS(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .wel(wel), .cmd_prot(cmd_prot),
    .cmd_unprot(cmd_unprot), .cmd_sec(cmd_sec), .sr_wr(sr_wr), .sr_lock(sr_lock),
    .sr_gbits(sr_gbits), .q_sec(q_sec), .q_chip(q_chip), .q_prot(q_prot),
    .q_allow(q_allow), .summary(summary), .locked(locked), .wel_clr(wel_clr));

  function automatic logic [1:0] exp_sum(logic [N-1:0] p);
    if (&p) return 2'b11;
    if (|p) return 2'b01;
    return 2'b00;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic query(string tag);
    for (int k = 0; k < 3; k++) begin
      q_sec  = SW'($urandom % N);
      q_chip = (k == 2);
      #1;
      chk(tag, q_prot, m_prot[q_sec]);
      chk("R9", q_allow, q_chip ? (m_prot == 0) : !m_prot[q_sec]);
    end
    q_chip = 0;
  endtask

  // kind: 0 protect, 1 unprotect, 2 status write, 3 idle, 4 collision of all three
  task automatic op(int kind, int sec, bit lk, logic [3:0] gb, bit w, bit wp);
    bit old;
    string tag;
    @(negedge clk);
    wp_n = wp; wel = w; cmd_sec = SW'(sec); sr_lock = lk; sr_gbits = gb;
    cmd_prot = (kind == 0 || kind == 4);
    cmd_unprot = (kind == 1 || kind == 4);
    sr_wr = (kind == 2 || kind == 4);
    old = m_lock;
    if (w && sr_wr) begin
      m_lock = (old && !wp) || lk;
      if (!old) begin
        if (gb == 4'hF)      m_prot = '1;
        else if (gb == 4'h0) m_prot = '0;
      end
    end else if (w && !old && cmd_prot) m_prot[sec] = 1'b1;
    else if (w && !old && cmd_unprot) m_prot[sec] = 1'b0;
    @(negedge clk);
    cmd_prot = 0; cmd_unprot = 0; sr_wr = 0;
    if (!w) tag = "R4";
    else if (old && kind != 3) tag = "R5";
    else if (kind == 4) tag = "R11";
    else if (kind == 2) tag = "R6";
    else if (kind == 1) tag = "R3";
    else tag = "R2";
    chk("R10", wel_clr, w && kind != 3);
    chk("R7", locked, m_lock);
    chk("R8", summary, exp_sum(m_prot));
    chk(tag, u_dut.q_prot === 1'bx ? 64'hx : 64'h0, 64'h0);
    checks--;
    query(tag);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EC7_0A11));
    m_prot = '1; m_lock = 0;
    repeat (3) @(negedge clk);
    chk("R1", summary, 2'b11);
    chk("R1", locked, 0);
    chk("R1", wel_clr, 0);
    rst_n = 1;
    query("R1");
    // R1 R8: single-sector unprotect walks summary from 11 to 01
    op(1, 5, 0, 4'h3, 1, 1);
    op(0, 5, 0, 4'h3, 1, 1);
    // R4: without write enable nothing changes
    op(1, 9, 0, 4'h0, 0, 1);
    op(2, 0, 1, 4'h0, 0, 1);
    // R6: global unprotect, then mixed bits keep state, then global protect
    op(2, 0, 0, 4'h0, 1, 1);
    op(0, 7, 0, 4'h5, 1, 1);
    op(2, 0, 0, 4'h9, 1, 1);
    op(2, 0, 0, 4'hF, 1, 1);
    // R6 R7: lock set in the same write as a global unprotect, judged on the old lock
    op(2, 0, 1, 4'h0, 1, 0);
    // R5: locked, so protect, unprotect and globals are ignored
    op(0, 3, 1, 4'h0, 1, 0);
    op(1, 3, 1, 4'h0, 1, 0);
    op(2, 0, 1, 4'hF, 1, 1);
    // R7: clearing the lock with wp_n low fails, with wp_n high succeeds, globals still skipped
    op(2, 0, 0, 4'hF, 1, 0);
    op(2, 0, 0, 4'hF, 1, 1);
    op(1, 2, 0, 4'h0, 1, 0);
    // R7: setting the lock with wp_n low is allowed
    op(2, 0, 1, 4'h3, 1, 0);
    op(2, 0, 0, 4'h3, 1, 1);
    // R11: collisions
    op(4, 2, 0, 4'h0, 1, 1);
    op(0, 2, 0, 4'h0, 1, 1);
    op(4, 2, 0, 4'h6, 1, 1);
    for (int i = 0; i < 3000; i++) begin
      int kind;
      logic [3:0] gb;
      kind = $urandom % 6;
      if (kind == 5) kind = 1;
      case ($urandom % 3)
        0: gb = 4'h0;
        1: gb = 4'hF;
        default: gb = 4'($urandom);
      endcase
      op(kind, $urandom % N, ($urandom % 5) == 0, gb, ($urandom % 8) != 0, $urandom % 2);
    end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule